// File: doc/BRIEF.md
# Dual-Clock Cell Buffer with Cell Counting

This block buffers fixed-length ATM cells between a writing clock domain and a reading clock domain. The two clocks may be one shared clock or two unrelated clocks. Words are stored in a dual-port RAM. The writer marks the last word of each complete cell with a one-cycle `wr_inc` pulse. The reader gives a one-cycle `rd_dec` pulse after it has consumed a cell. Each domain keeps its own copy of the stored-cell count. The opposite domain's events reach that copy through toggle synchronizers.

The reader sees `rd_cell_avail` while at least one finished cell is unread. It sees `rd_empty` while no committed word remains to be fetched. The writer sees `wr_afull` once the buffer holds its full quota of cells. Data of a cell becomes visible to the reader only when the cell is committed.

The writer can give up on a partly written cell. A word written with `wr_soc` while a cell is still open throws away the open cell's words. That word is then stored as word 0 of a fresh cell.

Top module: `cell_fifo`

## Requirements
- R1: After reset `rd_empty` is 1, `rd_cell_avail` is 0 and `wr_afull` is 0.
- R2: Words come out in the order they were committed. Each `rd_en` accepted while `rd_empty` is 0 presents the next word on `rd_data` one `rd_clk` cycle later.
- R3: A `wr_inc` pulse (given in the cycle of the cell's last write, CELL_WORDS words after the cell's first word) adds one cell to the count. A `rd_dec` pulse removes one. `rd_cell_avail` is 1 exactly while the read-side count is non-zero.
- R4: `wr_afull` rises in the cycle after the commit that brings the write-side count to CELLS (default 9). It falls again once a `rd_dec` has crossed to the write side.
- R5: Words of a cell not yet committed by `wr_inc` are invisible to the reader. `rd_empty` stays 1 and `rd_cell_avail` stays 0.
- R6: A write with `wr_soc`=1 while a cell is open drops the open cell's words. The current word becomes word 0 of the new cell and is the first word read.
- R7: `rd_en` while `rd_empty` is 1 is ignored. The next committed cell is still read from its first word.
- R8: `rd_dec` while the read-side count is zero is ignored. The count does not wrap, so `rd_cell_avail` stays 0.
- R9: `rd_empty` is word-level. It rises after the last committed word is fetched, even while `rd_cell_avail` is still 1 because no `rd_dec` has been given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| wr_rst | input | 1 | Synchronous active-high reset, write side |
| wr_en | input | 1 | Write one word |
| wr_soc | input | 1 | Word is the first of a cell |
| wr_data | input | DW | Write word |
| wr_inc | input | 1 | Commit the current cell (pulse) |
| wr_afull | output | 1 | No room for another complete cell |
| rd_clk | input | 1 | Read-side clock |
| rd_rst | input | 1 | Synchronous active-high reset, read side |
| rd_en | input | 1 | Fetch one word |
| rd_data | output | DW | Fetched word, valid one cycle after `rd_en` |
| rd_dec | input | 1 | Release one cell (pulse) |
| rd_empty | output | 1 | No committed word left to fetch |
| rd_cell_avail | output | 1 | At least one complete cell unread |

## Verification
The assertions take several things for granted about the inputs:
- every `wr_inc` arrives exactly CELL_WORDS words after the cell's first word;
- no new cell is started while `wr_afull` is high;
- commit and release pulses in one domain are far enough apart for the other domain to see each toggle.

The stimulus writes every cell as an unbroken run of words, with the commit pulse on the last word. It starts a cell only when `wr_afull` is low and its own model holds fewer than CELLS cells. It gives at most one `rd_dec` per cell read, spaced by several read cycles. Aborted partial cells are always shorter than a cell.

// File: rtl/cfifo_pkg.sv
package cfifo_pkg;
  // address bits needed to hold the given number of cells
  function automatic int unsigned addr_bits(int unsigned cells, int unsigned words);
    return $clog2(cells * words);
  endfunction

  // bits needed for a count from 0 to cells
  function automatic int unsigned count_bits(int unsigned cells);
    return $clog2(cells + 1);
  endfunction
endpackage

// File: rtl/cfifo_evt_sync.sv
module cfifo_evt_sync #(
  parameter int ASYNC  = 1,
  parameter int STAGES = 2
) (
  input  logic src_clk,
  input  logic src_rst,
  input  logic src_evt,
  input  logic dst_clk,
  input  logic dst_rst,
  output logic dst_evt
);
  logic tog_q;
  logic tap;
  logic last_q;

  always_ff @(posedge src_clk) begin
    if (src_rst) tog_q <= 1'b0;
    else if (src_evt) tog_q <= ~tog_q;
  end

  generate
    if (ASYNC != 0) begin : g_async
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge dst_clk) begin
        if (dst_rst) sh_q <= '0;
        else sh_q <= {sh_q[STAGES-2:0], tog_q};
      end
      assign tap = sh_q[STAGES-1];
    end else begin : g_shared
      assign tap = tog_q;
    end
  endgenerate

  always_ff @(posedge dst_clk) begin
    if (dst_rst) last_q <= 1'b0;
    else last_q <= tap;
  end

  assign dst_evt = tap ^ last_q;
endmodule

// File: rtl/cfifo_ram.sv
module cfifo_ram #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rclk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge rclk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/cfifo_wr_ctrl.sv
module cfifo_wr_ctrl #(
  parameter int CELL_WORDS = 27,
  parameter int CELLS      = 9,
  parameter int AW         = 8,
  parameter int CNTW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_soc,
  input  logic          inc,
  input  logic          dec_evt,
  output logic          mem_we,
  output logic [AW-1:0] mem_waddr,
  output logic          afull
);
  localparam int PW = AW + 1;

  logic [PW-1:0]   ptr_q, start_q, ptr_n, addr_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            open_cell, restart, down;
  logic            afull_q;

  assign open_cell = (ptr_q != start_q);
  assign restart   = wr_en && wr_soc && open_cell;
  assign down      = dec_evt && (cnt_q != '0);

  always_comb begin
    addr_n = restart ? start_q : ptr_q;
    ptr_n  = wr_en ? addr_n + PW'(1) : ptr_q;
    cnt_n  = cnt_q;
    if (inc && !down) cnt_n = cnt_q + CNTW'(1);
    else if (!inc && down) cnt_n = cnt_q - CNTW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      start_q <= '0;
      cnt_q   <= '0;
      afull_q <= 1'b0;
    end else begin
      ptr_q <= ptr_n;
      if (inc) start_q <= ptr_n;
      cnt_q   <= cnt_n;
      afull_q <= (cnt_n >= CNTW'(CELLS));
    end
  end

  assign mem_we    = wr_en;
  assign mem_waddr = addr_n[AW-1:0];
  assign afull     = afull_q;

  // R3: a commit closes a cell of exactly CELL_WORDS words
  assert_cell_len_R3: assert property (@(posedge clk) disable iff (rst)
    inc |-> ((ptr_n - start_q) == PW'(CELL_WORDS)));
  // R6: a restart rewinds to the open cell's first address
  assert_rewind_R6: assert property (@(posedge clk) disable iff (rst)
    restart |=> (ptr_q == $past(start_q) + PW'(1)));
  // R4: write-side count never passes capacity
  assert_wcount_max_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNTW'(CELLS));
endmodule

// File: rtl/cfifo_rd_ctrl.sv
module cfifo_rd_ctrl #(
  parameter int CELL_WORDS = 27,
  parameter int CELLS      = 9,
  parameter int AW         = 8,
  parameter int CNTW       = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_en,
  input  logic          dec,
  input  logic          inc_evt,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          dec_ok,
  output logic          empty,
  output logic          avail
);
  localparam int PW = AW + 1;

  logic [PW-1:0]   ptr_q, end_q, ptr_n, end_n;
  logic [CNTW-1:0] cnt_q, cnt_n;
  logic            take, down;
  logic            empty_q, avail_q;

  assign take = rd_en && !empty_q;
  assign down = dec && (cnt_q != '0);

  always_comb begin
    ptr_n = take ? ptr_q + PW'(1) : ptr_q;
    end_n = inc_evt ? end_q + PW'(CELL_WORDS) : end_q;
    cnt_n = cnt_q;
    if (inc_evt && !down) cnt_n = cnt_q + CNTW'(1);
    else if (!inc_evt && down) cnt_n = cnt_q - CNTW'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr_q   <= '0;
      end_q   <= '0;
      cnt_q   <= '0;
      empty_q <= 1'b1;
      avail_q <= 1'b0;
    end else begin
      ptr_q   <= ptr_n;
      end_q   <= end_n;
      cnt_q   <= cnt_n;
      empty_q <= (ptr_n == end_n);
      avail_q <= (cnt_n != '0);
    end
  end

  assign mem_re    = take;
  assign mem_raddr = ptr_q[AW-1:0];
  assign dec_ok    = down;
  assign empty     = empty_q;
  assign avail     = avail_q;

  // R7: a fetch on an empty buffer does not move the read pointer
  assert_no_fetch_empty_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty_q) |=> $stable(ptr_q));
  // R3: availability only appears after a commit crossed over
  assert_avail_rise_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(avail_q) |-> $past(inc_evt));
  // R8: read-side count stays within capacity
  assert_rcount_max_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNTW'(CELLS));
  // R9: unread committed words never exceed the capacity
  assert_backlog_R9: assert property (@(posedge clk) disable iff (rst)
    (end_q - ptr_q) <= PW'(CELLS * CELL_WORDS));
endmodule

// File: rtl/cell_fifo.sv
module cell_fifo #(
  parameter int DW          = 16,
  parameter int CELL_WORDS  = 27,
  parameter int CELLS       = 9,
  parameter int ASYNC       = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst,
  input  logic          wr_en,
  input  logic          wr_soc,
  input  logic [DW-1:0] wr_data,
  input  logic          wr_inc,
  output logic          wr_afull,
  input  logic          rd_clk,
  input  logic          rd_rst,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  input  logic          rd_dec,
  output logic          rd_empty,
  output logic          rd_cell_avail
);
  localparam int AW   = cfifo_pkg::addr_bits(CELLS, CELL_WORDS);
  localparam int CNTW = cfifo_pkg::count_bits(CELLS);

  logic          mem_we, mem_re;
  logic [AW-1:0] mem_waddr, mem_raddr;
  logic          inc_to_rd, dec_ok, dec_to_wr;

  cfifo_wr_ctrl #(.CELL_WORDS(CELL_WORDS), .CELLS(CELLS), .AW(AW), .CNTW(CNTW)) u_wr (
    .clk(wr_clk), .rst(wr_rst), .wr_en(wr_en), .wr_soc(wr_soc), .inc(wr_inc),
    .dec_evt(dec_to_wr), .mem_we(mem_we), .mem_waddr(mem_waddr), .afull(wr_afull)
  );

  cfifo_rd_ctrl #(.CELL_WORDS(CELL_WORDS), .CELLS(CELLS), .AW(AW), .CNTW(CNTW)) u_rd (
    .clk(rd_clk), .rst(rd_rst), .rd_en(rd_en), .dec(rd_dec), .inc_evt(inc_to_rd),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .dec_ok(dec_ok),
    .empty(rd_empty), .avail(rd_cell_avail)
  );

  cfifo_evt_sync #(.ASYNC(ASYNC), .STAGES(SYNC_STAGES)) u_inc_sync (
    .src_clk(wr_clk), .src_rst(wr_rst), .src_evt(wr_inc),
    .dst_clk(rd_clk), .dst_rst(rd_rst), .dst_evt(inc_to_rd)
  );

  cfifo_evt_sync #(.ASYNC(ASYNC), .STAGES(SYNC_STAGES)) u_dec_sync (
    .src_clk(rd_clk), .src_rst(rd_rst), .src_evt(dec_ok),
    .dst_clk(wr_clk), .dst_rst(wr_rst), .dst_evt(dec_to_wr)
  );

  cfifo_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .rclk(rd_clk), .re(mem_re), .raddr(mem_raddr), .rdata(rd_data)
  );
endmodule

// File: tb/sim_cell_fifo.sv
module sim_cell_fifo;
  localparam int DW = 16;
  localparam int CW = 27;
  localparam int NC = 9;

  logic wr_clk = 1'b0, rd_clk = 1'b0;
  logic wr_rst = 1'b1, rd_rst = 1'b1;
  logic wr_en = 1'b0, wr_soc = 1'b0, wr_inc = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic rd_en = 1'b0, rd_dec = 1'b0;
  logic wr_afull, rd_empty, rd_cell_avail;
  logic [DW-1:0] rd_data;

  int nchecks = 0;
  int nerrs = 0;
  int unsigned salt = 0;
  int q[$];
  int next_id = 10;

  always #2 wr_clk = ~wr_clk;   // 250 MHz
  always #3.5 rd_clk = ~rd_clk;

  cell_fifo #(.DW(DW), .CELL_WORDS(CW), .CELLS(NC), .ASYNC(1), .SYNC_STAGES(2)) u0 (
    .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_en(wr_en), .wr_soc(wr_soc), .wr_data(wr_data),
    .wr_inc(wr_inc), .wr_afull(wr_afull), .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_en(rd_en),
    .rd_data(rd_data), .rd_dec(rd_dec), .rd_empty(rd_empty), .rd_cell_avail(rd_cell_avail)
  );

  function automatic logic [DW-1:0] exp_word(int id, int idx);
    return DW'(id * 40503 + idx * 257 + int'(salt));
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nchecks++;
    if (!ok) begin
      nerrs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put_words(int id, int n, bit commit);
    for (int i = 0; i < n; i++) begin
      @(negedge wr_clk);
      wr_en = 1'b1; wr_soc = (i == 0); wr_data = exp_word(id, i);
      wr_inc = commit && (i == n - 1);
    end
    @(negedge wr_clk);
    wr_en = 1'b0; wr_soc = 1'b0; wr_inc = 1'b0;
  endtask

  task automatic release_cell();
    @(negedge rd_clk); rd_dec = 1'b1;
    @(negedge rd_clk); rd_dec = 1'b0;
    repeat (3) @(negedge rd_clk);
  endtask

  task automatic fetch_cell(int id, string first_tag);
    for (int i = 0; i < CW; i++) begin
      @(negedge rd_clk); rd_en = 1'b1;
      @(negedge rd_clk); rd_en = 1'b0;
      check(rd_data == exp_word(id, i), (i == 0) ? first_tag : "R2",
            int'(rd_data), int'(exp_word(id, i)));
    end
  endtask

  task automatic wait_avail();
    for (int k = 0; k < 40 && !rd_cell_avail; k++) @(negedge rd_clk);
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    nerrs++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end

  initial begin
    salt = $urandom(32'h5EED);
    repeat (6) @(negedge rd_clk);
    wr_rst = 1'b0; rd_rst = 1'b0;
    @(negedge wr_clk);
    check(rd_empty == 1'b1, "R1", rd_empty, 1);
    check(rd_cell_avail == 1'b0, "R1", rd_cell_avail, 0);
    check(wr_afull == 1'b0, "R1", wr_afull, 0);

    // R5: open cell stays hidden
    put_words(900, 10, 1'b0);
    repeat (20) @(negedge rd_clk);
    check(rd_empty == 1'b1, "R5", rd_empty, 1);
    check(rd_cell_avail == 1'b0, "R5", rd_cell_avail, 0);

    // R6: new start-of-cell drops the open cell
    put_words(1, CW, 1'b1);
    wait_avail();
    check(rd_cell_avail == 1'b1, "R3", rd_cell_avail, 1);
    fetch_cell(1, "R6");
    check(rd_empty == 1'b1, "R9", rd_empty, 1);
    check(rd_cell_avail == 1'b1, "R9", rd_cell_avail, 1);
    release_cell();
    check(rd_cell_avail == 1'b0, "R3", rd_cell_avail, 0);

    // R7: fetch while empty ignored; R8: release at zero ignored
    repeat (2) begin
      @(negedge rd_clk); rd_en = 1'b1;
      @(negedge rd_clk); rd_en = 1'b0;
    end
    release_cell();
    repeat (6) @(negedge rd_clk);
    check(rd_cell_avail == 1'b0, "R8", rd_cell_avail, 0);
    put_words(2, CW, 1'b1);
    wait_avail();
    fetch_cell(2, "R7");
    release_cell();
    repeat (12) @(negedge wr_clk);
    check(wr_afull == 1'b0, "R4", wr_afull, 0);

    // R4: fill to capacity
    for (int c = 0; c < NC; c++) begin
      put_words(100 + c, CW, 1'b1);
      check(wr_afull == (c == NC - 1), "R4", wr_afull, int'(c == NC - 1));
    end
    wait_avail();
    fetch_cell(100, "R2");
    release_cell();
    repeat (12) @(negedge wr_clk);
    check(wr_afull == 1'b0, "R4", wr_afull, 0);
    for (int c = 1; c < NC; c++) begin
      wait_avail();
      check(rd_cell_avail == 1'b1, "R3", rd_cell_avail, 1);
      fetch_cell(100 + c, "R2");
      release_cell();
    end
    check(rd_empty == 1'b1, "R9", rd_empty, 1);
    check(rd_cell_avail == 1'b0, "R3", rd_cell_avail, 0);

    // random mix of writes, aborts and reads
    for (int it = 0; it < 60; it++) begin
      int r;
      r = $urandom_range(0, 2);
      if ((r != 0 || q.size() == 0) && !wr_afull && q.size() < NC) begin
        if ($urandom_range(0, 3) == 0)
          put_words(next_id + 5000, $urandom_range(1, CW - 1), 1'b0);
        put_words(next_id, CW, 1'b1);
        q.push_back(next_id);
        next_id++;
      end else if (q.size() > 0) begin
        int id;
        wait_avail();
        check(rd_cell_avail == 1'b1, "R3", rd_cell_avail, 1);
        id = q.pop_front();
        fetch_cell(id, "R6");
        release_cell();
      end else begin
        repeat (10) @(negedge wr_clk);
      end
    end
    while (q.size() > 0) begin
      int id;
      wait_avail();
      id = q.pop_front();
      fetch_cell(id, "R2");
      release_cell();
    end
    repeat (10) @(negedge rd_clk);
    check(rd_empty == 1'b1, "R9", rd_empty, 1);
    check(rd_cell_avail == 1'b0, "R3", rd_cell_avail, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchecks, nerrs);
    $finish;
  end
endmodule